// File: doc/BRIEF.md
# Axis-Stepping Frame Buffer Access Port

This block is the host side of a bit-planed frame buffer. A host reaches it through one register-style access per cycle. Plain registers hold the cursor position, a small mode word, a per-plane write mask and an 8-bit pattern word. A data access reads or writes the pixel under the cursor. It can then move the cursor along a programmable major axis, along the minor axis, along both, or leave it in place.

Data accesses come in three families. A plain access always transfers. A patterned access writes only when the top bit of the pattern word is 1, and the pattern then rotates. A wide access covers ten horizontally adjacent pixels and moves X by ten. The memory devices, scanout timing and any drawing sequencer lie outside the block. The block drives the pixel coordinates, write strobes and per-plane enables toward the memory, and returns its read data to the host in the same cycle.

Top module: `vmem_step_port`

## Requirements
- R1: After reset, X and Y are 0, the mode word is 0, the write mask is all ones, the pattern word is 8'hFF, and no write strobe is active.
- R2: A host write with `acc_addr_i[4]`=0 loads a register, and a read returns it zero-extended. The codes are 0 for the mode word, 1 for the write mask, 2 for the pattern word, 3 for X and 4 for Y.
- R3: A data access uses `acc_addr_i` = {1, family[1:0], variant[1:0]}, where family 0 is plain, 1 is patterned and 2 is wide. It presents the current cursor on `mem_x_o`/`mem_y_o`. A plain write raises `mem_we_o` in that cycle and drives `acc_wdata_i[7:0]` on `mem_wdata_o`.
- R4: Variant bit 0 steps the major axis and variant bit 1 steps the minor axis, so variant 0 leaves the cursor unchanged. Mode bit 0 picks the major axis (0 = X, 1 = Y). The step takes effect at the clock edge that ends the access.
- R5: Mode bit 1 makes major steps decrement, and mode bit 2 makes minor steps decrement. Otherwise steps increment.
- R6: X wraps modulo 1280 in both directions.
- R7: Y wraps modulo 960 when mode bit 3 is 0 and modulo 1024 when it is 1.
- R8: A patterned write raises no strobe while pattern bit 7 is 0.
- R9: Every patterned access, whether it reads, writes or is blocked, rotates the pattern word left by one, with bit 7 moving to bit 0.
- R10: A wide access raises `mem_wide_o`, and X moves by 10 instead of 1 when it is stepped. Y still moves by 1.
- R11: A data read raises no strobe, ignores the pattern bit, returns `mem_rdata_i` on `acc_rdata_o` and moves the cursor exactly as a write would.
- R12: `mem_plane_we_o` equals the write mask during a write strobe and is 0 otherwise, so planes whose mask bit is 0 are never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Host access this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 5 | Register code or data family/variant |
| acc_wdata_i | input | 16 | Host write data |
| acc_rdata_o | output | 16 | Host read data (combinational) |
| mem_x_o | output | 11 | Cursor X toward memory |
| mem_y_o | output | 10 | Cursor Y toward memory |
| mem_wide_o | output | 1 | Access spans ten pixels from X |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_plane_we_o | output | 8 | Per-plane write enables |
| mem_wdata_o | output | 8 | Pixel data, one bit per plane |
| mem_rdata_i | input | 8 | Pixel data read from memory |

## Verification
A single patterned access does three things at once. It makes the write-or-block decision from the current pattern bit, it rotates the pattern, and it steps the cursor, while the memory still has to see the coordinates from before the step. The bench loads patterns whose top bit alternates and issues patterned writes and reads with stepping variants back to back. For each access, the scoreboard computes the strobe and coordinates from the pre-access model state and compares them mid-cycle. A read of the pattern register afterwards shows that blocked accesses and reads rotated it too.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  typedef enum logic [1:0] {
    FAM_PLAIN = 2'd0,
    FAM_STIP  = 2'd1,
    FAM_WIDE  = 2'd2,
    FAM_NONE  = 2'd3
  } fam_e;

  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_WMASK = 3'd1,
    REG_PAT   = 3'd2,
    REG_XPOS  = 3'd3,
    REG_YPOS  = 3'd4
  } reg_e;

  // mode word bit positions
  localparam int MODE_W      = 4;
  localparam int MODE_MAJ_Y  = 0;
  localparam int MODE_MAJ_DN = 1;
  localparam int MODE_MIN_DN = 2;
  localparam int MODE_TALL   = 3;

  typedef struct packed {
    logic       data;
    logic       reg_hit;
    logic       wr;
    fam_e       fam;
    logic       step_maj;
    logic       step_min;
    logic [2:0] reg_idx;
  } acc_t;
endpackage

// File: rtl/vsp_decode.sv
module vsp_decode
  import vsp_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [4:0] addr_i,
  output acc_t       acc_o
);
  always_comb begin
    acc_o          = '0;
    acc_o.wr       = write_i;
    acc_o.fam      = fam_e'(addr_i[3:2]);
    acc_o.step_maj = addr_i[0];
    acc_o.step_min = addr_i[1];
    acc_o.reg_idx  = addr_i[2:0];
    acc_o.data     = valid_i & addr_i[4] & (fam_e'(addr_i[3:2]) != FAM_NONE);
    acc_o.reg_hit  = valid_i & ~addr_i[4];
  end
endmodule

// File: rtl/vsp_axis_ctr.sv
module vsp_axis_ctr #(
  parameter int W  = 11,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  load_val_i,
  input  logic          step_i,
  input  logic          dec_i,
  input  logic [SW-1:0] stride_i,
  input  logic [W:0]    limit_i,
  output logic [W-1:0]  cnt_o
);
  localparam int EW = W + 2;

  logic [W-1:0]  cnt_q, nxt;
  logic [EW-1:0] cur, stp, lim, up, dn;

  assign cur = EW'(cnt_q);
  assign stp = EW'(stride_i);
  assign lim = EW'(limit_i);

  always_comb begin
    up = cur + stp;
    if (up >= lim) up = up - lim;
    dn  = (cur >= stp) ? (cur - stp) : (cur + lim - stp);
    nxt = W'(dec_i ? dn : up);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vsp_pattern.sv
module vsp_pattern #(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [SW-1:0] load_val_i,
  input  logic          rot_i,
  output logic [SW-1:0] pat_o,
  output logic          gate_o
);
  logic [SW-1:0] pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pat_q <= '1;
    else if (load_i) pat_q <= load_val_i;
    else if (rot_i)  pat_q <= {pat_q[SW-2:0], pat_q[SW-1]};
  end

  assign pat_o  = pat_q;
  assign gate_o = pat_q[SW-1];
endmodule

// File: rtl/vmem_step_port.sv
module vmem_step_port
  import vsp_pkg::*;
#(
  parameter int PLANES   = 8,
  parameter int DATA_W   = 16,
  parameter int X_SPAN   = 1280,
  parameter int Y_SHORT  = 960,
  parameter int Y_TALL   = 1024,
  parameter int WIDE_PIX = 10,
  parameter int PAT_W    = 8,
  localparam int XW      = $clog2(X_SPAN),
  localparam int YW      = $clog2(Y_TALL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [4:0]        acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic [XW-1:0]     mem_x_o,
  output logic [YW-1:0]     mem_y_o,
  output logic              mem_wide_o,
  output logic              mem_rd_o,
  output logic              mem_we_o,
  output logic [PLANES-1:0] mem_plane_we_o,
  output logic [PLANES-1:0] mem_wdata_o,
  input  logic [PLANES-1:0] mem_rdata_i
);
  localparam int STR_W = $clog2(WIDE_PIX + 1);

  acc_t              acc;
  logic [MODE_W-1:0] mode_q;
  logic [PLANES-1:0] wmask_q;
  logic [PAT_W-1:0]  pat;
  logic              pat_gate;
  logic [XW-1:0]     x_cnt;
  logic [YW-1:0]     y_cnt;
  logic              reg_wr, ld_x, ld_y, ld_pat;
  logic              x_step, y_step, x_dn, y_dn;
  logic [STR_W-1:0]  x_stride;
  logic [YW:0]       y_lim;

  vsp_decode u_dec (
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .addr_i  (acc_addr_i),
    .acc_o   (acc)
  );

  assign reg_wr = acc.reg_hit & acc.wr;
  assign ld_x   = reg_wr & (acc.reg_idx == REG_XPOS);
  assign ld_y   = reg_wr & (acc.reg_idx == REG_YPOS);
  assign ld_pat = reg_wr & (acc.reg_idx == REG_PAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      wmask_q <= '1;
    end else if (reg_wr) begin
      if (acc.reg_idx == REG_MODE)  mode_q  <= acc_wdata_i[MODE_W-1:0];
      if (acc.reg_idx == REG_WMASK) wmask_q <= acc_wdata_i[PLANES-1:0];
    end
  end

  // route major/minor steps onto the physical axes
  always_comb begin
    if (mode_q[MODE_MAJ_Y]) begin
      y_step = acc.data & acc.step_maj;
      y_dn   = mode_q[MODE_MAJ_DN];
      x_step = acc.data & acc.step_min;
      x_dn   = mode_q[MODE_MIN_DN];
    end else begin
      x_step = acc.data & acc.step_maj;
      x_dn   = mode_q[MODE_MAJ_DN];
      y_step = acc.data & acc.step_min;
      y_dn   = mode_q[MODE_MIN_DN];
    end
  end

  assign x_stride = (acc.fam == FAM_WIDE) ? STR_W'(WIDE_PIX) : STR_W'(1);
  assign y_lim    = mode_q[MODE_TALL] ? (YW+1)'(Y_TALL) : (YW+1)'(Y_SHORT);

  vsp_axis_ctr #(.W(XW), .SW(STR_W)) u_x (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_x),
    .load_val_i (acc_wdata_i[XW-1:0]),
    .step_i     (x_step),
    .dec_i      (x_dn),
    .stride_i   (x_stride),
    .limit_i    ((XW+1)'(X_SPAN)),
    .cnt_o      (x_cnt)
  );

  vsp_axis_ctr #(.W(YW), .SW(STR_W)) u_y (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_y),
    .load_val_i (acc_wdata_i[YW-1:0]),
    .step_i     (y_step),
    .dec_i      (y_dn),
    .stride_i   (STR_W'(1)),
    .limit_i    (y_lim),
    .cnt_o      (y_cnt)
  );

  vsp_pattern #(.SW(PAT_W)) u_pat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_pat),
    .load_val_i (acc_wdata_i[PAT_W-1:0]),
    .rot_i      (acc.data & (acc.fam == FAM_STIP)),
    .pat_o      (pat),
    .gate_o     (pat_gate)
  );

  assign mem_x_o        = x_cnt;
  assign mem_y_o        = y_cnt;
  assign mem_wide_o     = acc.data & (acc.fam == FAM_WIDE);
  assign mem_rd_o       = acc.data & ~acc.wr;
  assign mem_we_o       = acc.data & acc.wr & ((acc.fam != FAM_STIP) | pat_gate);
  assign mem_plane_we_o = {PLANES{mem_we_o}} & wmask_q;
  assign mem_wdata_o    = acc_wdata_i[PLANES-1:0];

  always_comb begin
    acc_rdata_o = '0;
    if (acc_addr_i[4]) acc_rdata_o = DATA_W'(mem_rdata_i);
    else begin
      unique case (acc.reg_idx)
        REG_MODE:  acc_rdata_o = DATA_W'(mode_q);
        REG_WMASK: acc_rdata_o = DATA_W'(wmask_q);
        REG_PAT:   acc_rdata_o = DATA_W'(pat);
        REG_XPOS:  acc_rdata_o = DATA_W'(x_cnt);
        REG_YPOS:  acc_rdata_o = DATA_W'(y_cnt);
        default:   acc_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vsp_step_port_chk.sv
module vsp_step_port_chk #(
  parameter int PLANES = 8,
  parameter int PAT_W  = 8,
  parameter int XW     = 11,
  parameter int YW     = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [4:0]        acc_addr_i,
  input logic [XW-1:0]     mem_x_o,
  input logic [YW-1:0]     mem_y_o,
  input logic              mem_we_o,
  input logic [PLANES-1:0] mem_plane_we_o,
  input logic [PLANES-1:0] wmask_q,
  input logic [PAT_W-1:0]  pat
);
  logic data_acc, pat_acc;
  assign data_acc = acc_valid_i & acc_addr_i[4] & (acc_addr_i[3:2] != 2'd3);
  assign pat_acc  = data_acc & (acc_addr_i[3:2] == 2'd1);

  a_r3_plane_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_plane_we_o != '0) |-> mem_we_o);

  a_r4_no_step_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && acc_addr_i[1:0] == 2'd0) |=> ($stable(mem_x_o) && $stable(mem_y_o)));

  a_r8_pattern_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_acc && acc_write_i && !pat[PAT_W-1]) |-> !mem_we_o);

  a_r9_pattern_rotates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_acc |=> (pat == {$past(pat[PAT_W-2:0]), $past(pat[PAT_W-1])}));

  a_r11_read_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i) |-> !mem_we_o);

  a_r12_mask_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_plane_we_o & ~wmask_q) == '0);
endmodule

bind vmem_step_port vsp_step_port_chk #(
  .PLANES(PLANES), .PAT_W(PAT_W), .XW(XW), .YW(YW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .acc_write_i    (acc_write_i),
  .acc_addr_i     (acc_addr_i),
  .mem_x_o        (mem_x_o),
  .mem_y_o        (mem_y_o),
  .mem_we_o       (mem_we_o),
  .mem_plane_we_o (mem_plane_we_o),
  .wmask_q        (wmask_q),
  .pat            (pat)
);

// File: tb/vmem_step_port_bench.sv
`timescale 1ns/1ps
module vmem_step_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [10:0] mx;
  logic [9:0]  my;
  logic        wide, rd, we;
  logic [7:0]  pwe, mwd, mrd;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vmem_step_port u_vmem_step_port (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(write),
    .acc_addr_i(addr), .acc_wdata_i(wdata), .acc_rdata_o(rdata),
    .mem_x_o(mx), .mem_y_o(my), .mem_wide_o(wide), .mem_rd_o(rd),
    .mem_we_o(we), .mem_plane_we_o(pwe), .mem_wdata_o(mwd), .mem_rdata_i(mrd)
  );

  function automatic logic [7:0] pix(input logic [10:0] x, input logic [9:0] y);
    return 8'((x * 3) ^ y);
  endfunction
  assign mrd = pix(mx, my);

  // bench model
  logic [3:0]  m_mode = 4'h0;
  logic [7:0]  m_mask = 8'hFF, m_pat = 8'hFF;
  int          m_x = 0, m_y = 0;

  typedef struct {
    bit          chk_rd;
    logic        we;
    logic [7:0]  pwe;
    logic [10:0] x;
    logic [9:0]  y;
    logic        wide;
    logic [15:0] rd;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic int wrap(input int v, input int s, input bit dn, input int lim);
    return dn ? (v + lim - s) % lim : (v + s) % lim;
  endfunction

  task automatic acc(input bit wr, input logic [4:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    bit isd;
    logic [1:0] fam;
    @(posedge clk); #1;
    valid = 1'b1; write = wr; addr = a; wdata = d;
    fam = a[3:2];
    isd = a[4] && fam != 2'd3;
    e.chk_rd = !wr;
    e.x = 11'(m_x); e.y = 10'(m_y);
    e.wide = isd && fam == 2'd2;
    e.we = isd && wr && (fam != 2'd1 || m_pat[7]);
    e.pwe = e.we ? m_mask : 8'h00;
    e.tag = tag;
    if (isd) e.rd = {8'h00, pix(11'(m_x), 10'(m_y))};
    else case (a[2:0])
      3'd0: e.rd = {12'h0, m_mode};
      3'd1: e.rd = {8'h0, m_mask};
      3'd2: e.rd = {8'h0, m_pat};
      3'd3: e.rd = 16'(m_x);
      3'd4: e.rd = 16'(m_y);
      default: e.rd = 16'h0;
    endcase
    q.push_back(e);
    @(posedge clk); #1;
    valid = 1'b0;
    if (!a[4] && wr) case (a[2:0])
      3'd0: m_mode = d[3:0];
      3'd1: m_mask = d[7:0];
      3'd2: m_pat  = d[7:0];
      3'd3: m_x    = int'(d[10:0]);
      3'd4: m_y    = int'(d[9:0]);
      default: ;
    endcase
    if (isd) begin
      bit majy = m_mode[0];
      bit xs = majy ? a[1] : a[0];
      bit ys = majy ? a[0] : a[1];
      bit xd = majy ? m_mode[2] : m_mode[1];
      bit yd = majy ? m_mode[1] : m_mode[2];
      int lim = m_mode[3] ? 1024 : 960;
      if (fam == 2'd1) m_pat = {m_pat[6:0], m_pat[7]};
      if (xs) m_x = wrap(m_x, (fam == 2'd2) ? 10 : 1, xd, 1280);
      if (ys) m_y = wrap(m_y, 1, yd, lim);
    end
  endtask

  function automatic logic [4:0] da(input int fam, input int v);
    return {1'b1, 2'(fam), 2'(v)};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nchk++;
      if (we !== e.we || pwe !== e.pwe || mx !== e.x || my !== e.y || wide !== e.wide ||
          (e.chk_rd && rdata !== e.rd) || (e.we && mwd !== wdata[7:0])) begin
        nerr++;
        $display("FAIL %s: we=%b pwe=%h x=%0d y=%0d wide=%b rd=%h | exp we=%b pwe=%h x=%0d y=%0d wide=%b rd=%h",
                 e.tag, we, pwe, mx, my, wide, rdata, e.we, e.pwe, e.x, e.y, e.wide, e.rd);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not end, exp finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    nchk++;
    if (we !== 1'b0 || mx !== 11'd0 || my !== 10'd0) begin
      nerr++;
      $display("FAIL R1 in reset: we=%b x=%0d y=%0d exp 0 0 0", we, mx, my);
    end
    rst_n = 1'b1;
    // R1 reset values
    acc(0, 5'd0, 0, "R1 mode");
    acc(0, 5'd1, 0, "R1 wmask");
    acc(0, 5'd2, 0, "R1 pattern");
    acc(0, 5'd3, 0, "R1 x");
    acc(0, 5'd4, 0, "R1 y");
    // R2 register load and read-back
    acc(1, 5'd3, 16'd5, "R2 wr x");
    acc(1, 5'd4, 16'd7, "R2 wr y");
    acc(0, 5'd3, 0, "R2 x");
    acc(0, 5'd4, 0, "R2 y");
    // R3 / R12 plain write through a mask
    acc(1, 5'd1, 16'hA5, "R12 wr mask");
    acc(1, da(0, 0), 16'h3C, "R3 R12 plain write");
    acc(0, 5'd1, 0, "R2 mask");
    // R4 stepping with X major, increments
    acc(1, 5'd0, 16'h0, "R4 mode");
    acc(1, da(0, 1), 16'h11, "R4 major");
    acc(1, da(0, 2), 16'h22, "R4 minor");
    acc(1, da(0, 3), 16'h33, "R4 both");
    acc(0, 5'd3, 0, "R4 x");
    acc(0, 5'd4, 0, "R4 y");
    // R5 Y major, both directions decrement
    acc(1, 5'd0, 16'h7, "R5 mode");
    acc(1, da(0, 1), 16'h44, "R5 major dec");
    acc(1, da(0, 2), 16'h55, "R5 minor dec");
    acc(0, 5'd3, 0, "R5 x");
    acc(0, 5'd4, 0, "R5 y");
    // R6 X wrap
    acc(1, 5'd0, 16'h0, "R6 mode");
    acc(1, 5'd3, 16'd1279, "R6 x");
    acc(1, da(0, 1), 16'h01, "R6 inc wrap");
    acc(1, 5'd0, 16'h2, "R6 mode dec");
    acc(1, da(0, 1), 16'h02, "R6 dec wrap");
    acc(0, 5'd3, 0, "R6 x");
    // R7 Y wrap at 960 and 1024
    acc(1, 5'd0, 16'h1, "R7 mode short");
    acc(1, 5'd4, 16'd959, "R7 y");
    acc(1, da(0, 1), 16'h03, "R7 wrap 960");
    acc(0, 5'd4, 0, "R7 y 0");
    acc(1, 5'd0, 16'h9, "R7 mode tall");
    acc(1, 5'd4, 16'd959, "R7 y");
    acc(1, da(0, 1), 16'h04, "R7 960 no wrap");
    acc(1, 5'd4, 16'd1023, "R7 y");
    acc(1, da(0, 1), 16'h05, "R7 wrap 1024");
    acc(0, 5'd4, 0, "R7 y 0 tall");
    // R8 / R9 pattern gating and rotation
    acc(1, 5'd0, 16'h0, "R8 mode");
    acc(1, 5'd2, 16'h5A, "R8 pattern");
    acc(1, da(1, 1), 16'h66, "R8 blocked");
    acc(1, da(1, 1), 16'h77, "R8 allowed");
    acc(0, 5'd2, 0, "R9 pattern after two");
    acc(0, da(1, 2), 0, "R11 R9 read with bit7 0");
    acc(0, 5'd2, 0, "R9 pattern after read");
    acc(0, 5'd3, 0, "R9 x");
    acc(0, 5'd4, 0, "R9 y");
    // R10 wide family
    acc(1, 5'd3, 16'd1275, "R10 x");
    acc(1, da(2, 1), 16'h88, "R10 wide major wrap");
    acc(1, da(2, 2), 16'h99, "R10 wide minor");
    acc(1, 5'd0, 16'h2, "R10 mode dec");
    acc(1, da(2, 3), 16'hAA, "R10 wide both dec");
    acc(0, 5'd3, 0, "R10 x");
    acc(0, 5'd4, 0, "R10 y");
    // R11 plain reads
    acc(0, da(0, 3), 0, "R11 read both");
    acc(0, da(0, 0), 0, "R11 read none");
    acc(0, da(2, 1), 0, "R11 wide read");
    acc(0, 5'd3, 0, "R11 x");
    repeat (3) @(posedge clk);
    nchk++;
    if (q.size() != 0) begin
      nerr++;
      $display("FAIL scoreboard: %0d items left, exp 0", q.size());
    end
    finish_run();
  end
endmodule